// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the master side of a three-wire serial EEPROM link. A client hands it one command at a time over a valid/ready port: the operation code, a word address, write data, the word width (8 or 16 bits) and, for reads, a burst length. The engine raises the select line, shifts out a start bit, a two-bit opcode, the address field and any write data MSB first on a divided serial clock, and samples the memory's serial output. On reads it drops the leading zero bit the memory inserts, assembles each word and presents it with a one-cycle word strobe. A burst keeps select high, so the memory streams consecutive words without a new command. Each command ends with a one-cycle done pulse.

After any command that programs the array (word write, word erase, whole-array erase, whole-array write), the engine drops select for the minimum deselect time and raises it again with clock and data low. It then polls the memory's output until it reads 1 (ready). Once ready is seen it sends one clock with data high, which clears the status, and drops select. If ready never comes within a tick budget the poll is abandoned and the done pulse carries an error flag.

The controller is a single state machine. S_IDLE waits for a command and moves to S_CSUP on acceptance. S_CSUP holds select high for one tick, then goes to S_LO. S_LO and S_HI alternate for each serial clock period. S_HI goes to S_END after the last bit. S_END leads to S_GAP. S_GAP enforces the deselect time, then goes to S_POLL for a program command not yet polled, and to S_FIN otherwise. S_POLL goes to S_CLRLO on ready, or back to S_GAP on timeout. S_CLRLO leads to S_CLRHI and then to S_GAP. S_FIN returns to S_IDLE.

Top module: `uwire_host`

## Requirements
- R1: Every frame is start bit 1, then a two-bit opcode (read 10, write 01, erase 11, others 00), then the address field, then write data, all MSB first. The 00-opcode commands carry a selector in the top two address bits: write-enable 11, write-disable 00, erase-all 10, write-all 01, with the rest of the field 0. The address field is 8 bits wide (cmd_addr[7:0]) in 16-bit mode and 9 bits wide in 8-bit mode. Command codes on cmd_op: 0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable, 5 erase-all, 6 write-all.
- R2: The first select assertion of a command carries exactly 11 clocks (16-bit mode) or 12 clocks (8-bit mode) for write-enable, write-disable, erase and erase-all. It carries 27 or 20 clocks for a single-word read, a write and a write-all.
- R3: Select rises only while the serial clock and data line are both low, and the data line changes only while the serial clock is low.
- R4: On a read, the bit sampled after the last address clock is discarded. Each following group of 16 (or 8) samples forms one word, given on rsp_rdata with a one-cycle rsp_word strobe. In 8-bit mode rsp_rdata[15:8] is 0.
- R5: A read with cmd_len = n returns n+1 consecutive words within one select assertion, using header + (n+1) x word-width clocks and no resent command.
- R6: Every deselect lasts at least GAP_TICKS x DIV system clocks before select rises again.
- R7: After a program command the engine deselects, reselects, waits for ee_do = 1, then gives exactly one clock with ee_di = 1 and deselects. Each program command therefore makes exactly two select assertions.
- R8: If ee_do stays 0 for POLL_LIMIT ticks, the engine deselects without the clearing clock and finishes with rsp_err = 1 on the done pulse.
- R9: Out of reset ee_cs, ee_sk and ee_di are 0 and cmd_ready is 1. cmd_ready is 0 from acceptance until completion. rsp_done is a one-cycle pulse.
- R10: Read, write-enable and write-disable make a single select assertion with no status poll, and finish with rsp_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted this cycle if valid |
| cmd_op | input | 3 | Command code (see R1) |
| cmd_addr | input | 9 | Word address |
| cmd_wdata | input | 16 | Write data (low byte in 8-bit mode) |
| cmd_x16 | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| cmd_len | input | LEN_W | Extra words for a read burst |
| rsp_word | output | 1 | Read word strobe |
| rsp_rdata | output | 16 | Read word |
| rsp_done | output | 1 | Command complete pulse |
| rsp_err | output | 1 | Status poll timed out (valid with rsp_done) |
| ee_cs | output | 1 | Serial select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data to memory |
| ee_do | input | 1 | Serial data / status from memory |

## Verification
A vector table runs every command code in both word widths. Comparing the captured first-assertion bit pattern and clock count tells the opcode and selector encodings apart, and shows the differing address widths and the 11/12 versus 27/20 frame lengths. Reads at ordinary addresses, at the top address of each mode (wrap-around) and with burst lengths 0, 1 and 2 show whether the dummy bit is dropped and whether words follow on without a resent command. A memory model that holds busy for a while, and one that never becomes ready, separate a normal poll-and-clear (two assertions, one clearing clock) from the timeout path (error set, no clearing clock).

// File: rtl/uwire_pkg.sv
package uwire_pkg;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_ERASE     = 3'd2,
        OP_WREN      = 3'd3,
        OP_WRDIS     = 3'd4,
        OP_ERASE_ALL = 3'd5,
        OP_WRITE_ALL = 3'd6
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CSUP, S_LO, S_HI, S_END, S_GAP, S_POLL, S_CLRLO, S_CLRHI, S_FIN
    } state_e;

    localparam int FRAME_W = 32;

endpackage

// File: rtl/uwire_tick.sv
module uwire_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/uwire_frame.sv
module uwire_frame
    import uwire_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int NB_W  = 9
) (
    input  op_e                  op,
    input  logic [8:0]           addr,
    input  logic [15:0]          wdata,
    input  logic                 x16,
    input  logic [LEN_W-1:0]     len,
    output logic [FRAME_W-1:0]   frame,
    output logic [NB_W-1:0]      nbits,
    output logic [3:0]           hdr_bits,
    output logic                 is_read,
    output logic                 is_prog
);
    logic [1:0]       opc, sel;
    logic             has_data;
    logic [8:0]       a9;
    logic [7:0]       a8;
    logic [LEN_W:0]   words;
    logic [NB_W-1:0]  rd_bits, dat_bits;

    always_comb begin
        opc      = 2'b00;
        sel      = 2'b00;
        has_data = 1'b0;
        is_read  = 1'b0;
        is_prog  = 1'b0;
        case (op)
            OP_READ:      begin opc = 2'b10; is_read = 1'b1; end
            OP_WRITE:     begin opc = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
            OP_ERASE:     begin opc = 2'b11; is_prog = 1'b1; end
            OP_WREN:      sel = 2'b11;
            OP_WRDIS:     sel = 2'b00;
            OP_ERASE_ALL: begin sel = 2'b10; is_prog = 1'b1; end
            OP_WRITE_ALL: begin sel = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
            default:      sel = 2'b00;
        endcase

        a9 = (opc == 2'b00) ? {sel, 7'b0} : addr;
        a8 = (opc == 2'b00) ? {sel, 6'b0} : addr[7:0];

        if (x16) frame = {1'b1, opc, a8, (has_data ? wdata : 16'h0000), 5'b0};
        else     frame = {1'b1, opc, a9, (has_data ? wdata[7:0] : 8'h00), 12'b0};

        hdr_bits = x16 ? 4'd11 : 4'd12;
        words    = {1'b0, len} + 1'b1;
        rd_bits  = is_read ? (NB_W'(words) << (x16 ? 4 : 3)) : '0;
        dat_bits = has_data ? (x16 ? NB_W'(16) : NB_W'(8)) : '0;
        nbits    = NB_W'(hdr_bits) + dat_bits + rd_bits;
    end
endmodule

// File: rtl/uwire_host.sv
module uwire_host
    import uwire_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int GAP_TICKS  = 4,
    parameter int POLL_LIMIT = 4096,
    parameter int LEN_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [2:0]       cmd_op,
    input  logic [8:0]       cmd_addr,
    input  logic [15:0]      cmd_wdata,
    input  logic             cmd_x16,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             rsp_word,
    output logic [15:0]      rsp_rdata,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic             ee_cs,
    output logic             ee_sk,
    output logic             ee_di,
    input  logic             ee_do
);
    localparam int MAX_BITS = 12 + 16 * (2 ** LEN_W);
    localparam int NB_W     = $clog2(MAX_BITS + 1);
    localparam int GAP_W    = $clog2(GAP_TICKS + 1);
    localparam int POLL_W   = $clog2(POLL_LIMIT + 1);
    localparam int MIN_LOW  = GAP_TICKS * DIV;

    state_e               state_q, state_d;
    logic                 tick;
    logic [FRAME_W-1:0]   f_frame, frame_q;
    logic [NB_W-1:0]      f_nbits, nbits_q, bitcnt_q;
    logic [3:0]           f_hdr, hdr_q;
    logic                 f_read, f_prog;
    logic                 x16_q, read_q, prog_q, polled_q, err_q;
    logic [GAP_W-1:0]     gap_q;
    logic [POLL_W-1:0]    poll_q;
    logic [15:0]          rx_q, rdata_q;
    logic [3:0]           wbit_q;
    logic                 word_q;
    logic                 last_bit, capture, word_end, gap_end, poll_end;

    uwire_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    uwire_frame #(.LEN_W(LEN_W), .NB_W(NB_W)) u_frame (
        .op(op_e'(cmd_op)), .addr(cmd_addr), .wdata(cmd_wdata), .x16(cmd_x16),
        .len(cmd_len), .frame(f_frame), .nbits(f_nbits), .hdr_bits(f_hdr),
        .is_read(f_read), .is_prog(f_prog)
    );

    assign last_bit = (bitcnt_q == nbits_q - NB_W'(1));
    assign capture  = read_q && (bitcnt_q >= NB_W'(hdr_q));
    assign word_end = (wbit_q == (x16_q ? 4'd15 : 4'd7));
    assign gap_end  = (gap_q == GAP_W'(GAP_TICKS - 1));
    assign poll_end = (poll_q == POLL_W'(POLL_LIMIT - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_valid) state_d = S_CSUP;
            S_CSUP:  if (tick) state_d = S_LO;
            S_LO:    if (tick) state_d = S_HI;
            S_HI:    if (tick) state_d = last_bit ? S_END : S_LO;
            S_END:   if (tick) state_d = S_GAP;
            S_GAP:   if (tick && gap_end) state_d = (prog_q && !polled_q) ? S_POLL : S_FIN;
            S_POLL:  if (tick) begin
                         if (ee_do)         state_d = S_CLRLO;
                         else if (poll_end) state_d = S_GAP;
                     end
            S_CLRLO: if (tick) state_d = S_CLRHI;
            S_CLRHI: if (tick) state_d = S_GAP;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0; nbits_q <= '0; hdr_q <= '0; bitcnt_q <= '0;
            x16_q <= 1'b0; read_q <= 1'b0; prog_q <= 1'b0; polled_q <= 1'b0;
            err_q <= 1'b0; gap_q <= '0; poll_q <= '0; rx_q <= '0;
            rdata_q <= '0; wbit_q <= '0; word_q <= 1'b0;
        end else begin
            word_q <= 1'b0;
            if (state_q == S_IDLE && cmd_valid) begin
                frame_q  <= f_frame;
                nbits_q  <= f_nbits;
                hdr_q    <= f_hdr;
                x16_q    <= cmd_x16;
                read_q   <= f_read;
                prog_q   <= f_prog;
                polled_q <= 1'b0;
                err_q    <= 1'b0;
                bitcnt_q <= '0;
                wbit_q   <= '0;
            end
            if (state_q == S_HI && tick) begin
                frame_q  <= frame_q << 1;
                bitcnt_q <= bitcnt_q + 1'b1;
                if (capture) begin
                    rx_q <= {rx_q[14:0], ee_do};
                    if (word_end) begin
                        word_q  <= 1'b1;
                        rdata_q <= x16_q ? {rx_q[14:0], ee_do} : {8'h00, rx_q[6:0], ee_do};
                        wbit_q  <= '0;
                    end else begin
                        wbit_q  <= wbit_q + 1'b1;
                    end
                end
            end
            gap_q  <= (state_q == S_GAP)  ? (tick ? gap_q + 1'b1  : gap_q)  : '0;
            poll_q <= (state_q == S_POLL) ? (tick ? poll_q + 1'b1 : poll_q) : '0;
            if (state_q == S_POLL && tick && !ee_do && poll_end) err_q <= 1'b1;
            if (state_q == S_POLL && tick && (ee_do || poll_end)) polled_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (state_q == S_IDLE);
        rsp_done  = (state_q == S_FIN);
        rsp_err   = err_q && (state_q == S_FIN);
        rsp_word  = word_q;
        rsp_rdata = rdata_q;
        ee_cs     = 1'b0;
        ee_sk     = 1'b0;
        ee_di     = 1'b0;
        unique case (state_q)
            S_CSUP, S_END, S_POLL: ee_cs = 1'b1;
            S_LO:    begin ee_cs = 1'b1; ee_di = frame_q[FRAME_W-1]; end
            S_HI:    begin ee_cs = 1'b1; ee_sk = 1'b1; ee_di = frame_q[FRAME_W-1]; end
            S_CLRLO: begin ee_cs = 1'b1; ee_di = 1'b1; end
            S_CLRHI: begin ee_cs = 1'b1; ee_sk = 1'b1; ee_di = 1'b1; end
            default: ee_cs = 1'b0;
        endcase
    end

    // deselect-time observer for the assertion below
    logic [15:0] low_cnt_q;
    logic        was_sel_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            was_sel_q <= 1'b0;
        end else begin
            if (ee_cs)                   low_cnt_q <= '0;
            else if (low_cnt_q != 16'hFFFF) low_cnt_q <= low_cnt_q + 1'b1;
            if (ee_cs) was_sel_q <= 1'b1;
        end
    end

    AST_CS_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs) |-> (!ee_sk && !ee_di)); // R3
    AST_DI_SK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ee_di) |-> !ee_sk); // R3
    AST_MIN_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ee_cs) && was_sel_q) |-> (low_cnt_q >= 16'(MIN_LOW))); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R9
    AST_POLL_PROG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POLL) |-> prog_q); // R10
    AST_ERR_AFTER_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (polled_q && prog_q)); // R8
    AST_WORD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_word |-> read_q); // R4
    AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LO || state_q == S_HI) |-> (bitcnt_q < nbits_q)); // R2
endmodule

// File: tb/uwire_host_test.sv
module uwire_host_test;
    localparam int DIV = 4, GAP = 4, PLIM = 40, BUSY = 100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_ready, cmd_x16 = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [8:0] cmd_addr = '0;
    logic [15:0] cmd_wdata = '0, rsp_rdata;
    logic [3:0] cmd_len = '0;
    logic rsp_word, rsp_done, rsp_err, ee_cs, ee_sk, ee_di, ee_do;

    always #5 clk = ~clk;

    uwire_host #(.DIV(DIV), .GAP_TICKS(GAP), .POLL_LIMIT(PLIM), .LEN_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_x16(cmd_x16),
        .cmd_len(cmd_len), .rsp_word(rsp_word), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] dev_word(input logic [8:0] a, input logic x16);
        if (x16) return {a[7:0] ^ 8'h5A, ~a[7:0]};
        return {8'h00, a[7:0] ^ 8'hC3 ^ {7'b0, a[8]}};
    endfunction

    function automatic logic [31:0] exp_frame(input logic [2:0] op, input logic [8:0] a,
                                              input logic [15:0] d, input logic x16);
        logic [1:0] oc = 2'b00, sl = 2'b00;
        logic dat = 1'b0;
        case (op)
            3'd0: oc = 2'b10;
            3'd1: begin oc = 2'b01; dat = 1'b1; end
            3'd2: oc = 2'b11;
            3'd3: sl = 2'b11;
            3'd5: sl = 2'b10;
            3'd6: begin sl = 2'b01; dat = 1'b1; end
            default: sl = 2'b00;
        endcase
        if (x16) return {1'b1, oc, (oc == 2'b00 ? {sl, 6'b0} : a[7:0]), (dat ? d : 16'h0), 5'b0};
        return {1'b1, oc, (oc == 2'b00 ? {sl, 7'b0} : a), (dat ? d[7:0] : 8'h0), 12'b0};
    endfunction

    // memory model
    logic cur_x16 = 1'b0, stuck = 1'b0;
    logic st_mode, rd_do, di1, pcs, psk, pdi;
    logic [31:0] fb0;
    int asrt, bitn, nclk0, nclk1, busy, gcnt, lowc, min_low, cs_bad, di_bad;
    bit seen_sel;
    logic [15:0] got [0:15];

    initial begin
        st_mode = 0; rd_do = 0; di1 = 0; pcs = 0; psk = 0; pdi = 0; fb0 = 0;
        asrt = 0; bitn = 0; nclk0 = 0; nclk1 = 0; busy = 0; gcnt = 0;
        lowc = 0; min_low = 1000000; cs_bad = 0; di_bad = 0; seen_sel = 0;
    end

    assign ee_do = ee_cs ? (st_mode ? (busy == 0) : rd_do) : 1'b0;

    always @(posedge clk) begin
        if (cmd_valid && cmd_ready) begin
            asrt = 0; st_mode = 0; busy = 0; nclk0 = 0; nclk1 = 0; di1 = 0; fb0 = 0; gcnt = 0;
        end
        if (busy > 0 && !stuck) busy = busy - 1;
        if (rsp_word) begin
            if (gcnt < 16) got[gcnt] = rsp_rdata;
            gcnt++;
        end
        if (ee_cs && !pcs) begin
            bitn = 0;
            if (ee_sk || ee_di) cs_bad++;
            if (seen_sel && lowc < min_low) min_low = lowc;
            seen_sel = 1;
        end
        if (!ee_cs) lowc++; else lowc = 0;
        if (ee_di != pdi && ee_sk) di_bad++;
        if (!ee_cs && pcs) begin
            if (asrt == 0) begin
                logic [1:0] op, sl;
                bit prog, dat;
                int full;
                nclk0 = bitn;
                op = fb0[30:29]; sl = fb0[28:27];
                prog = (op == 2'b01) || (op == 2'b11) || (op == 2'b00 && (sl == 2'b10 || sl == 2'b01));
                dat  = (op == 2'b01) || (op == 2'b00 && sl == 2'b01);
                full = cur_x16 ? (dat ? 27 : 11) : (dat ? 20 : 12);
                if (prog && bitn == full) begin st_mode = 1; busy = BUSY; end
            end else if (asrt == 1) nclk1 = bitn;
            asrt++;
            rd_do = 0;
        end
        if (ee_cs && ee_sk && !psk) begin
            bitn++;
            if (st_mode && ee_di) begin st_mode = 0; if (asrt == 1) di1 = 1; end
            if (asrt == 0 && bitn <= 32) fb0[32 - bitn] = ee_di;
            if (asrt == 0 && fb0[31:29] == 3'b110) begin
                int h, w, idx, a, b;
                logic [15:0] dw;
                h = cur_x16 ? 11 : 12;
                w = cur_x16 ? 16 : 8;
                if (bitn == h) rd_do = 0;
                else if (bitn > h) begin
                    idx = bitn - h - 1;
                    a = cur_x16 ? ((int'(fb0[28:21]) + idx / w) % 256)
                                : ((int'(fb0[28:20]) + idx / w) % 512);
                    b = w - 1 - (idx % w);
                    dw = dev_word(9'(a), cur_x16);
                    rd_do = dw[b];
                end
            end
        end
        pcs = ee_cs; psk = ee_sk; pdi = ee_di;
    end

    typedef struct packed {
        logic [2:0] op; logic [8:0] addr; logic [15:0] wdata;
        logic x16; logic [3:0] len; logic [8:0] nclk; logic [1:0] nasrt;
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{3'd3, 9'h000, 16'h0000, 1'b1, 4'd0, 9'd11, 2'd1},
        '{3'd1, 9'h03C, 16'hBEEF, 1'b1, 4'd0, 9'd27, 2'd2},
        '{3'd0, 9'h012, 16'h0000, 1'b1, 4'd0, 9'd27, 2'd1},
        '{3'd0, 9'h1A5, 16'h0000, 1'b0, 4'd0, 9'd20, 2'd1},
        '{3'd2, 9'h0F3, 16'h0000, 1'b0, 4'd0, 9'd12, 2'd2},
        '{3'd5, 9'h000, 16'h0000, 1'b1, 4'd0, 9'd11, 2'd2},
        '{3'd6, 9'h000, 16'h005A, 1'b0, 4'd0, 9'd20, 2'd2},
        '{3'd4, 9'h000, 16'h0000, 1'b0, 4'd0, 9'd12, 2'd1},
        '{3'd0, 9'h0FE, 16'h0000, 1'b1, 4'd2, 9'd59, 2'd1},
        '{3'd1, 9'h100, 16'h00C3, 1'b0, 4'd0, 9'd20, 2'd2},
        '{3'd0, 9'h1FF, 16'h0000, 1'b0, 4'd1, 9'd28, 2'd1},
        '{3'd2, 9'h1AB, 16'h0000, 1'b1, 4'd0, 9'd11, 2'd2}
    };

    logic done_err;

    task automatic run_cmd(input logic [2:0] op, input logic [8:0] a, input logic [15:0] d,
                           input logic x16, input logic [3:0] len);
        int n;
        @(negedge clk);
        cur_x16 = x16;
        cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_x16 = x16; cmd_len = len;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R9", "ready low while busy", 32'(cmd_ready), 0);
        n = 0;
        while (!rsp_done && n < 20000) begin @(negedge clk); n++; end
        chk(rsp_done == 1'b1, "R9", "done seen", 32'(rsp_done), 1);
        done_err = rsp_err;
        @(negedge clk);
        chk(rsp_done == 1'b0 && cmd_ready == 1'b1, "R9", "done one cycle, ready back",
            {30'b0, rsp_done, cmd_ready}, 32'h1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, cmd_ready, rsp_done} == 5'b00010, "R9", "in reset outputs",
            32'({ee_cs, ee_sk, ee_di, cmd_ready, rsp_done}), 32'h2);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, cmd_ready, rsp_done} == 5'b00010, "R9", "after reset outputs",
            32'({ee_cs, ee_sk, ee_di, cmd_ready, rsp_done}), 32'h2);

        foreach (VECS[i]) begin
            vec_t v;
            logic [31:0] ef;
            v = VECS[i];
            run_cmd(v.op, v.addr, v.wdata, v.x16, v.len);
            ef = exp_frame(v.op, v.addr, v.wdata, v.x16);
            chk(fb0 == ef, "R1", $sformatf("frame bits vec %0d", i), fb0, ef);
            chk(nclk0 == int'(v.nclk), (v.len != 0) ? "R5" : "R2",
                $sformatf("clock count vec %0d", i), 32'(nclk0), 32'(v.nclk));
            chk(asrt == int'(v.nasrt), (v.nasrt == 2) ? "R7" : "R10",
                $sformatf("select assertions vec %0d", i), 32'(asrt), 32'(v.nasrt));
            chk(done_err == 1'b0, "R10", $sformatf("no error vec %0d", i), 32'(done_err), 0);
            if (v.nasrt == 2) begin
                chk(nclk1 == 1 && di1 == 1'b1, "R7", $sformatf("status clear clock vec %0d", i),
                    32'(nclk1), 1);
            end
            if (v.op == 3'd0) begin
                chk(gcnt == int'(v.len) + 1, (v.len != 0) ? "R5" : "R4",
                    $sformatf("word count vec %0d", i), 32'(gcnt), 32'(int'(v.len) + 1));
                for (int w = 0; w <= int'(v.len); w++) begin
                    int a;
                    logic [15:0] ew;
                    a = v.x16 ? ((int'(v.addr[7:0]) + w) % 256) : ((int'(v.addr) + w) % 512);
                    ew = dev_word(9'(a), v.x16);
                    chk(got[w] == ew, (v.len != 0) ? "R5" : "R4",
                        $sformatf("read word %0d vec %0d", w, i), 32'(got[w]), 32'(ew));
                end
            end
        end

        // R8: memory never reports ready
        stuck = 1'b1;
        run_cmd(3'd2, 9'h044, 16'h0, 1'b1, 4'd0);
        chk(done_err == 1'b1, "R8", "timeout error flag", 32'(done_err), 1);
        chk(asrt == 2 && nclk1 == 0, "R8", "no clearing clock after timeout", 32'(nclk1), 0);
        stuck = 1'b0;

        // R10: read after timeout is clean again
        run_cmd(3'd0, 9'h077, 16'h0, 1'b1, 4'd0);
        chk(done_err == 1'b0 && asrt == 1, "R10", "read after timeout", 32'(asrt), 1);

        // R3 / R6 line-level observations over the whole run
        chk(cs_bad == 0, "R3", "select rose with clock or data high", 32'(cs_bad), 0);
        chk(di_bad == 0, "R3", "data changed while clock high", 32'(di_bad), 0);
        chk(min_low >= GAP * DIV, "R6", "shortest deselect", 32'(min_low), 32'(GAP * DIV));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule